// File: doc/BRIEF.md
# Card Window Address Decoder

This block compares each host bus address with eight programmable windows that map host space onto a card socket. Each window has a base register and an option register. The option register holds a valid flag, a size code, a target slot, an address space selector (common memory, attribute memory or I/O), a bus width flag, a write-protect flag and three access-timing fields. The block finds the window that contains the host address, reports that window's attributes, and gives the card-side address. There is no offset register, so the card-side address is the host address minus the window base.

Software programs the windows through a simple register-write port. The register address holds the window number in its upper bits, and bit 0 selects base (0) or option (1), so each window's option register sits directly after its base register. Decoding is combinational from the host address. Register writes take effect from the next clock cycle. When a write access hits a write-protected window, the block raises a violation flag and withholds the card write strobe.

Top module: `card_win_decoder`

## Requirements
- R1: After reset every base and option register is zero, so no host address hits and every output is zero.
- R2: A write with `wr_addr_i` = 2·n stores window n's base, and `wr_addr_i` = 2·n+1 stores its option register. The new value is used from the clock cycle after the write edge.
- R3: Base registers have 4 KiB resolution: bits 11:0 of the written base are dropped and behave as zero.
- R4: The size code in option bits 31:27 is a 5-bit Gray code. Its Gray-to-binary value e gives a window of 2^e bytes. For example, code 0 is 1 byte, 2 is 8 bytes, 3 is 4 bytes, 4 is 128 bytes and 23 is 64 MiB. Codes where e is greater than 26 (16 to 19, and 22) are illegal, and such a window never hits.
- R5: A window hits when option bit 0 (valid) is set, its size code is legal, and (host address AND NOT(size-1)) equals its base.
- R6: When several windows hit, the lowest-numbered window is selected and reported on `win_idx_o`.
- R7: On a hit the outputs carry fields from the selected option register: slot = bit 2, space = bits 4:3 (00 common, 10 attribute, 11 I/O), wide = bit 6, write-protect = bit 1, strobe length = bits 11:7, setup = bits 15:12, hold = bits 19:16. With no hit they are zero.
- R8: On a hit `card_addr_o` is the host address minus the selected base, and it is always below the window size. With no hit it is zero.
- R9: A write access (`hwrite_i`=1) that hits a write-protected window sets `viol_o` and keeps `card_we_o` low. A write that hits an unprotected window sets `card_we_o`. Reads never set either.
- R10: Writing zero to a window's option register disables that window from the next cycle.
- R11: With `hvalid_i` low, `hit_o`, `viol_o`, `card_we_o` and all attribute outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 4 | Register index: window number in bits 3:1, base/option select in bit 0 |
| wr_data_i | input | 32 | Register write data |
| hvalid_i | input | 1 | Host access valid |
| hwrite_i | input | 1 | Host access is a write |
| haddr_i | input | 32 | Host address |
| hit_o | output | 1 | Some window contains the address |
| win_idx_o | output | 3 | Selected window |
| slot_o | output | 1 | Target slot (0 = first, 1 = second) |
| space_o | output | 2 | Address space of the selected window |
| wide_o | output | 1 | 16-bit access width |
| wprot_o | output | 1 | Selected window is write-protected |
| strobe_o | output | 5 | Strobe length in clocks |
| setup_o | output | 4 | Setup time in clocks |
| hold_o | output | 4 | Hold time in clocks |
| card_addr_o | output | 32 | Card-side address |
| viol_o | output | 1 | Write to a protected window |
| card_we_o | output | 1 | Permitted card write strobe |

## Verification
Two functions can fall in the same cycle: a register write and a host access. The bench drives `wr_en_i` together with an access to the window being rewritten, most notably when an option register is cleared. The result must still reflect the old contents during that cycle and the new contents from the next one. The other case is overlapping windows. Several windows are programmed to cover one address, and the bench judges that the lowest index wins and that its attributes and its base, not those of another hitting window, drive every output.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  typedef struct packed {
    logic [4:0] size_code;
    logic [6:0] rsvd_hi;
    logic [3:0] hold;
    logic [3:0] setup;
    logic [4:0] strobe;
    logic       wide;
    logic       rsvd5;
    logic [1:0] space;
    logic       slot;
    logic       wprot;
    logic       valid;
  } opt_t;

  // Gray-coded size code to log2(size)
  function automatic logic [4:0] code_to_exp(input logic [4:0] c);
    logic [4:0] b;
    b[4] = c[4];
    for (int i = 3; i >= 0; i--) b[i] = b[i+1] ^ c[i];
    return b;
  endfunction
endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
  import cwd_pkg::*;
#(
  parameter int N_WIN    = 8,
  parameter int AW       = 32,
  parameter int BASE_LSB = 12,
  localparam int WIN_W   = $clog2(N_WIN),
  localparam int WA      = WIN_W + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [WA-1:0]                wr_addr_i,
  input  logic [AW-1:0]                wr_data_i,
  output logic [N_WIN-1:0][AW-1:0]     base_o,
  output opt_t [N_WIN-1:0]             opt_o
);
  logic [WIN_W-1:0] wr_win;
  assign wr_win = wr_addr_i[WA-1:1];

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[w] <= '0;
        opt_o[w]  <= '0;
      end else if (wr_en_i && wr_win == WIN_W'(w)) begin
        if (wr_addr_i[0]) opt_o[w] <= opt_t'(wr_data_i[31:0]);
        else              base_o[w] <= {wr_data_i[AW-1:BASE_LSB], BASE_LSB'(0)};
      end
    end
  end

  // R10
  opt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i[0] && wr_data_i[31:0] == '0) |=> !opt_o[$past(wr_win)].valid);
endmodule

// File: rtl/cwd_win_match.sv
module cwd_win_match
  import cwd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_EXP = 26
) (
  input  logic [AW-1:0] base_i,
  input  opt_t          opt_i,
  input  logic [AW-1:0] haddr_i,
  output logic          hit_o,
  output logic [AW-1:0] off_o
);
  logic [4:0]    exp_w;
  logic [AW-1:0] mask;
  logic          legal;

  always_comb begin
    exp_w = code_to_exp(opt_i.size_code);
    legal = (int'(exp_w) <= MAX_EXP);
    mask  = (AW'(1) << exp_w) - AW'(1);
    hit_o = opt_i.valid && legal && ((haddr_i & ~mask) == base_i);
    off_o = haddr_i - base_i;
  end
endmodule

// File: rtl/cwd_prio_sel.sv
module cwd_prio_sel #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  hit_vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit_vec_i[i]) idx_o = IW'(i);
    any_o = |hit_vec_i;
  end

  // R6
  prio_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (hit_vec_i[idx_o] && ((hit_vec_i & ((N'(1) << idx_o) - N'(1))) == '0)));
endmodule

// File: rtl/card_win_decoder.sv
module card_win_decoder
  import cwd_pkg::*;
#(
  parameter int N_WIN    = 8,
  parameter int AW       = 32,
  parameter int BASE_LSB = 12,
  parameter int MAX_EXP  = 26,
  localparam int WIN_W   = $clog2(N_WIN),
  localparam int WA      = WIN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WA-1:0]    wr_addr_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic             hvalid_i,
  input  logic             hwrite_i,
  input  logic [AW-1:0]    haddr_i,
  output logic             hit_o,
  output logic [WIN_W-1:0] win_idx_o,
  output logic             slot_o,
  output logic [1:0]       space_o,
  output logic             wide_o,
  output logic             wprot_o,
  output logic [4:0]       strobe_o,
  output logic [3:0]       setup_o,
  output logic [3:0]       hold_o,
  output logic [AW-1:0]    card_addr_o,
  output logic             viol_o,
  output logic             card_we_o
);
  logic [N_WIN-1:0][AW-1:0] base_q;
  opt_t [N_WIN-1:0]         opt_q;
  logic [N_WIN-1:0]         hit_vec;
  logic [N_WIN-1:0][AW-1:0] off_w;
  logic                     any_hit;
  logic [WIN_W-1:0]         sel_idx;
  opt_t                     sel_opt;
  logic                     wr_acc;

  cwd_regfile #(.N_WIN(N_WIN), .AW(AW), .BASE_LSB(BASE_LSB)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .base_o(base_q), .opt_o(opt_q)
  );

  for (genvar w = 0; w < N_WIN; w++) begin : g_match
    cwd_win_match #(.AW(AW), .MAX_EXP(MAX_EXP)) u_match (
      .base_i(base_q[w]), .opt_i(opt_q[w]), .haddr_i,
      .hit_o(hit_vec[w]), .off_o(off_w[w])
    );
  end

  cwd_prio_sel #(.N(N_WIN)) u_prio (
    .clk_i, .rst_ni, .hit_vec_i(hit_vec), .any_o(any_hit), .idx_o(sel_idx)
  );

  always_comb begin
    hit_o   = hvalid_i && any_hit;
    sel_opt = hit_o ? opt_q[sel_idx] : '0;
    win_idx_o   = hit_o ? sel_idx : '0;
    card_addr_o = hit_o ? off_w[sel_idx] : '0;
    slot_o   = sel_opt.slot;
    space_o  = sel_opt.space;
    wide_o   = sel_opt.wide;
    wprot_o  = sel_opt.wprot;
    strobe_o = sel_opt.strobe;
    setup_o  = sel_opt.setup;
    hold_o   = sel_opt.hold;
    wr_acc    = hit_o && hwrite_i;
    viol_o    = wr_acc && sel_opt.wprot;
    card_we_o = wr_acc && !sel_opt.wprot;
  end

  // R9
  we_viol_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(viol_o && card_we_o));
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hvalid_i |-> (!hit_o && !viol_o && !card_we_o));
  // R8
  off_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((card_addr_o >> code_to_exp(opt_q[win_idx_o].size_code)) == '0));
endmodule

// File: tb/card_win_decoder_bench.sv
`timescale 1ns/1ps
module card_win_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hvalid = 1'b0, hwrite = 1'b0;
  logic [31:0] haddr = '0;
  logic        hit, slot, wide, wprot, viol, we;
  logic [2:0]  idx;
  logic [1:0]  space;
  logic [4:0]  strobe;
  logic [3:0]  setup, hold;
  logic [31:0] caddr;

  int errors = 0, checks = 0;
  logic [31:0] base_m [8];
  logic [31:0] opt_m  [8];

  always #4 clk = ~clk;

  card_win_decoder u_card_win_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hvalid_i(hvalid), .hwrite_i(hwrite), .haddr_i(haddr),
    .hit_o(hit), .win_idx_o(idx), .slot_o(slot), .space_o(space), .wide_o(wide),
    .wprot_o(wprot), .strobe_o(strobe), .setup_o(setup), .hold_o(hold),
    .card_addr_o(caddr), .viol_o(viol), .card_we_o(we)
  );

  function automatic int size_exp(input logic [4:0] c);
    case (c)
      0: return 0;   1: return 1;   2: return 3;   3: return 2;
      4: return 7;   5: return 6;   6: return 4;   7: return 5;
      8: return 15;  9: return 14;  10: return 12; 11: return 13;
      12: return 8;  13: return 9;  14: return 11; 15: return 10;
      20: return 24; 21: return 25; 23: return 26;
      24: return 16; 25: return 17; 26: return 19; 27: return 18;
      28: return 23; 29: return 22; 30: return 20; 31: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [4:0] c);
    return (32'd1 << size_exp(c)) - 32'd1;
  endfunction

  function automatic logic [55:0] model(input logic [31:0] a, input logic v, input logic w);
    logic [55:0] r;
    r = '0;
    if (v) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] o;
        o = opt_m[k];
        if (o[0] && size_exp(o[31:27]) >= 0 &&
            ((a & ~size_mask(o[31:27])) == base_m[k])) begin
          r = {1'b1, 3'(k), o[2], o[4:3], o[6], o[1], o[11:7], o[15:12], o[19:16],
               a - base_m[k], w & o[1], w & ~o[1]};
          break;
        end
      end
    end
    return r;
  endfunction

  task automatic wreg(input int win, input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'((win << 1) | int'(sel)); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (sel) opt_m[win] = d; else base_m[win] = d & 32'hFFFF_F000;
  endtask

  task automatic acc(input logic [31:0] a, input logic w, input logic v, input string tag);
    logic [55:0] exp_v, act;
    @(negedge clk);
    haddr = a; hwrite = w; hvalid = v;
    #1;
    exp_v = model(a, v, w);
    act = {hit, idx, slot, space, wide, wprot, strobe, setup, hold, caddr, viol, we};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, a, act, exp_v);
    end
  endtask

  function automatic logic [31:0] mkopt(input logic [4:0] code, input logic [3:0] hd,
      input logic [3:0] su, input logic [4:0] st, input logic wd, input logic [1:0] sp,
      input logic sl, input logic wp, input logic vl);
    return {code, 7'd0, hd, su, st, wd, 1'b0, sp, sl, wp, vl};
  endfunction

  initial begin
    #1_200_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int k = 0; k < 8; k++) begin base_m[k] = '0; opt_m[k] = '0; end
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    acc(32'h0, 1'b0, 1'b1, "R1");
    acc(32'h4000_0000, 1'b1, 1'b1, "R1");

    // R2 R5 R7: window 2, 64 KiB (code 24)
    wreg(2, 1'b0, 32'h4000_0000);
    wreg(2, 1'b1, mkopt(5'd24, 4'd5, 4'd3, 5'd9, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1));
    acc(32'h4000_1234, 1'b0, 1'b1, "R7");
    acc(32'h4000_FFFF, 1'b0, 1'b1, "R5");
    acc(32'h4001_0000, 1'b0, 1'b1, "R5");
    acc(32'h3FFF_FFFF, 1'b0, 1'b1, "R5");
    acc(32'h4000_8000, 1'b1, 1'b1, "R8");

    // R3 low base bits dropped
    wreg(3, 1'b0, 32'h0012_3ABC);
    wreg(3, 1'b1, mkopt(5'd10, 4'd1, 4'd1, 5'd2, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1));
    acc(32'h0012_3000, 1'b0, 1'b1, "R3");
    acc(32'h0012_3FFF, 1'b0, 1'b1, "R3");
    acc(32'h0012_4000, 1'b0, 1'b1, "R3");

    // R4 small and illegal size codes
    wreg(4, 1'b0, 32'h0000_1000);
    wreg(4, 1'b1, mkopt(5'd2, 4'd0, 4'd0, 5'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
    acc(32'h0000_1007, 1'b0, 1'b1, "R4");
    acc(32'h0000_1008, 1'b0, 1'b1, "R4");
    foreach (opt_m[k]) ;
    for (int c = 16; c <= 22; c++) begin
      if (c == 20 || c == 21) continue;
      wreg(4, 1'b1, mkopt(5'(c), 4'd0, 4'd0, 5'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
      acc(32'h0000_1000, 1'b0, 1'b1, "R4");
    end
    wreg(4, 1'b1, mkopt(5'd23, 4'd0, 4'd0, 5'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
    acc(32'h0000_1000, 1'b0, 1'b1, "R4");
    wreg(4, 1'b0, 32'h0800_0000);
    acc(32'h0BFF_FFFF, 1'b0, 1'b1, "R4");
    acc(32'h0C00_0000, 1'b0, 1'b1, "R4");

    // R6 overlap: windows 5 and 1 cover the same region
    wreg(5, 1'b0, 32'h7000_0000);
    wreg(5, 1'b1, mkopt(5'd24, 4'd2, 4'd2, 5'd4, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
    wreg(1, 1'b0, 32'h7000_0000);
    wreg(1, 1'b1, mkopt(5'd10, 4'd7, 4'd6, 5'd12, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1));
    acc(32'h7000_0100, 1'b0, 1'b1, "R6");
    acc(32'h7000_2100, 1'b0, 1'b1, "R6");

    // R9 write protection
    wreg(6, 1'b0, 32'h9000_0000);
    wreg(6, 1'b1, mkopt(5'd30, 4'd1, 4'd1, 5'd3, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1));
    acc(32'h9000_0040, 1'b1, 1'b1, "R9");
    acc(32'h9000_0040, 1'b0, 1'b1, "R9");
    acc(32'h4000_0040, 1'b1, 1'b1, "R9");

    // R10 clear option, access in the write cycle sees old contents
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd3; wr_data = '0;
    haddr = 32'h7000_0100; hvalid = 1'b1; hwrite = 1'b0;
    #1;
    checks++;
    if (!(hit === 1'b1 && idx === 3'd1)) begin
      errors++;
      $display("FAIL R10 same-cycle act=%b/%0d exp=1/1", hit, idx);
    end
    @(posedge clk); #1;
    wr_en = 1'b0; opt_m[1] = '0;
    acc(32'h7000_0100, 1'b0, 1'b1, "R10");

    // R11 no access
    acc(32'h9000_0040, 1'b1, 1'b0, "R11");
    acc(32'h4000_0000, 1'b0, 1'b0, "R11");

    // random mix
    for (int it = 0; it < 400; it++) begin
      if (it % 25 == 0) begin
        int w;
        logic [4:0] c;
        logic [31:0] b;
        w = int'($urandom_range(0, 7));
        c = 5'($urandom);
        b = $urandom & 32'hFFFF_F000;
        if (size_exp(c) >= 0) b = b & ~size_mask(c);
        wreg(w, 1'b0, b);
        wreg(w, 1'b1, ($urandom & 32'hF80F_FFDF) | 32'(($urandom_range(0, 7) != 0)));
      end
      begin
        int w;
        logic [31:0] a;
        w = int'($urandom_range(0, 7));
        if ($urandom_range(0, 3) != 0 && size_exp(opt_m[w][31:27]) >= 0)
          a = base_m[w] + ($urandom & size_mask(opt_m[w][31:27]));
        else
          a = $urandom;
        acc(a, 1'($urandom), 1'($urandom_range(0, 7) != 0), "R5 R8 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule